// File: doc/BRIEF.md
# Quiz Buzzer Lockout Arbiter

This block decides which of three quiz contestants holds the floor. Each contestant has a buzzer line. While nobody is answering, the first contestant who presses and is still eligible wins the floor. A judge then rules the answer right or wrong. A wrong answer bars that contestant for the rest of the current question, and the floor opens again to the others. A right answer ends the question and clears every bar.

The whole machine is one register. It holds a lockout flag for each contestant and a small code for the contestant who is answering. A synchronous clear input starts a fresh question from any state. There is no data stream. All pins are plain level-sensitive controls, sampled on the rising clock edge. The outputs come straight from the state register, so they change in the cycle after the input that causes the change.

Top module: `quiz_lockout_arbiter`

## Requirements
- R1: Asserting `rst_n` low, or holding `clear_i` high at a clock edge, returns the machine to the empty state: no locks, code 0, no grant. `clear_i` takes priority over every other input.
- R2: When nobody is answering, a press from an unlocked contestant makes that contestant the answerer at the next edge. The lock flags stay unchanged.
- R3: If several unlocked contestants press in the same cycle, the lowest-numbered one (player 1 before 2 before 3) wins.
- R4: A press from a locked contestant is ignored.
- R5: While someone answers, `judge_bad_i` (without `judge_ok_i`) sets that contestant's lock flag and returns the code to 0.
- R6: While someone answers and neither judge input is high, the state holds.
- R7: While someone answers, `judge_ok_i` returns the machine to the empty state.
- R8: Presses that arrive while someone is answering are ignored.
- R9: Both judge inputs are ignored while nobody is answering.
- R10: Once all three lock flags are set, the state stays fixed until a clear or reset.
- R11: If `judge_ok_i` and `judge_bad_i` are high together, the ruling counts as correct (R7).
- R12: `player_code_o` encodes the answerer as 1, 2 or 3 for players 1 to 3, and 0 for nobody. `grant_o[i]` is high exactly when player i+1 answers. `lock_o[i]` is player i+1's lock flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clear_i | input | 1 | Synchronous new-question clear |
| buzz_i | input | 3 | Buzzer presses, bit i is player i+1 |
| judge_ok_i | input | 1 | Answer ruled correct |
| judge_bad_i | input | 1 | Answer ruled wrong |
| grant_o | output | 3 | One-hot floor grant |
| player_code_o | output | 2 | Answerer code, 0 means none |
| lock_o | output | 3 | Per-player lockout flags |

## Verification
The walk presses single buzzers, then groups of buzzers with different contestants already locked. Groups show that the lowest *eligible* contestant wins, not simply the lowest pressed bit. Presses and rulings are also applied in the phase where they must be ignored, which separates a correct hold from a leak of inputs into the state. A full lockout followed by further presses, simultaneous right/wrong rulings, and a clear that arrives together with a press separate the priority orderings.

// File: rtl/quiz_pkg.sv
package quiz_pkg;
  parameter int unsigned QZ_PLAYERS = 3;
  parameter int unsigned QZ_CODE_W  = $clog2(QZ_PLAYERS + 1);
endpackage

// File: rtl/quiz_first_pick.sv
module quiz_first_pick #(
  parameter int unsigned N  = quiz_pkg::QZ_PLAYERS,
  parameter int unsigned CW = quiz_pkg::QZ_CODE_W
) (
  input  logic [N-1:0]  req_i,
  output logic          hit_o,
  output logic [CW-1:0] code_o
);
  // Scan from the top so the lowest index is written last and wins.
  always_comb begin
    hit_o  = 1'b0;
    code_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req_i[i]) begin
        hit_o  = 1'b1;
        code_o = CW'(i + 1);
      end
    end
  end
endmodule

// File: rtl/quiz_grant_decode.sv
module quiz_grant_decode #(
  parameter int unsigned N  = quiz_pkg::QZ_PLAYERS,
  parameter int unsigned CW = quiz_pkg::QZ_CODE_W
) (
  input  logic [CW-1:0] code_i,
  output logic [N-1:0]  grant_o
);
  for (genvar g = 0; g < N; g++) begin : g_dec
    assign grant_o[g] = (code_i == CW'(g + 1));
  end
endmodule

// File: rtl/quiz_next_state.sv
module quiz_next_state #(
  parameter int unsigned N  = quiz_pkg::QZ_PLAYERS,
  parameter int unsigned CW = quiz_pkg::QZ_CODE_W
) (
  input  logic          clear_i,
  input  logic          ok_i,
  input  logic          bad_i,
  input  logic [N-1:0]  lock_i,
  input  logic [CW-1:0] code_i,
  input  logic [N-1:0]  owner_i,
  input  logic          pick_hit_i,
  input  logic [CW-1:0] pick_code_i,
  output logic [N-1:0]  lock_o,
  output logic [CW-1:0] code_o
);
  always_comb begin
    lock_o = lock_i;
    code_o = code_i;
    if (clear_i) begin
      lock_o = '0;
      code_o = '0;
    end else if (code_i == '0) begin
      if (pick_hit_i) code_o = pick_code_i;
    end else if (ok_i) begin
      lock_o = '0;
      code_o = '0;
    end else if (bad_i) begin
      lock_o = lock_i | owner_i;
      code_o = '0;
    end
  end
endmodule

// File: rtl/quiz_lockout_arbiter.sv
module quiz_lockout_arbiter (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clear_i,
  input  logic [2:0] buzz_i,
  input  logic       judge_ok_i,
  input  logic       judge_bad_i,
  output logic [2:0] grant_o,
  output logic [1:0] player_code_o,
  output logic [2:0] lock_o
);
  import quiz_pkg::*;
  localparam int unsigned N  = QZ_PLAYERS;
  localparam int unsigned CW = QZ_CODE_W;

  logic [N-1:0]  lock_q, lock_d, grant;
  logic [CW-1:0] code_q, code_d, pick_code;
  logic          pick_hit;

  quiz_first_pick #(.N(N), .CW(CW)) u_pick (
    .req_i (buzz_i & ~lock_q),
    .hit_o (pick_hit),
    .code_o(pick_code)
  );

  quiz_grant_decode #(.N(N), .CW(CW)) u_dec (
    .code_i (code_q),
    .grant_o(grant)
  );

  quiz_next_state #(.N(N), .CW(CW)) u_ns (
    .clear_i    (clear_i),
    .ok_i       (judge_ok_i),
    .bad_i      (judge_bad_i),
    .lock_i     (lock_q),
    .code_i     (code_q),
    .owner_i    (grant),
    .pick_hit_i (pick_hit),
    .pick_code_i(pick_code),
    .lock_o     (lock_d),
    .code_o     (code_d)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lock_q <= '0;
      code_q <= '0;
    end else begin
      lock_q <= lock_d;
      code_q <= code_d;
    end
  end

  assign grant_o       = grant;
  assign player_code_o = code_q;
  assign lock_o        = lock_q;

  a_r1_clear_empties: assert property (@(posedge clk) disable iff (!rst_n)
    clear_i |=> (code_q == '0) && (lock_q == '0));

  a_r5_wrong_locks_owner: assert property (@(posedge clk) disable iff (!rst_n)
    (!clear_i && code_q != '0 && judge_bad_i && !judge_ok_i)
      |=> (code_q == '0) && (lock_q == ($past(lock_q) | $past(grant))));

  a_r6_hold_without_ruling: assert property (@(posedge clk) disable iff (!rst_n)
    (!clear_i && code_q != '0 && !judge_bad_i && !judge_ok_i)
      |=> $stable(code_q) && $stable(lock_q));

  a_r4_locks_only_grow: assert property (@(posedge clk) disable iff (!rst_n)
    (!clear_i && !judge_ok_i) |=> ((lock_q & $past(lock_q)) == $past(lock_q)));

  a_r10_full_lock_sticks: assert property (@(posedge clk) disable iff (!rst_n)
    (!clear_i && lock_q == '1) |=> (lock_q == '1) && (code_q == '0));

  a_r12_grant_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant) && ((code_q == '0) == (grant == '0)));
endmodule

// File: tb/quiz_lockout_arbiter_tb.sv
`timescale 1ns/1ps
module quiz_lockout_arbiter_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       clear_i = 1'b0;
  logic [2:0] buzz_i = '0;
  logic       judge_ok_i = 1'b0;
  logic       judge_bad_i = 1'b0;
  logic [2:0] grant_o;
  logic [1:0] player_code_o;
  logic [2:0] lock_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  quiz_lockout_arbiter u_dut (
    .clk(clk), .rst_n(rst_n), .clear_i(clear_i), .buzz_i(buzz_i),
    .judge_ok_i(judge_ok_i), .judge_bad_i(judge_bad_i),
    .grant_o(grant_o), .player_code_o(player_code_o), .lock_o(lock_o)
  );

  // {clear, buzz[2:0], ok, bad, exp_code[1:0], exp_lock[2:0]}
  localparam int NV = 18;
  localparam logic [10:0] VEC [NV] = '{
    {1'b0, 3'b000, 1'b1, 1'b1, 2'd0, 3'b000},  // R9 rulings while idle
    {1'b0, 3'b010, 1'b0, 1'b0, 2'd2, 3'b000},  // R2 player 2 alone
    {1'b0, 3'b101, 1'b0, 1'b0, 2'd2, 3'b000},  // R8 presses while answering
    {1'b0, 3'b000, 1'b0, 1'b0, 2'd2, 3'b000},  // R6 hold
    {1'b0, 3'b000, 1'b0, 1'b1, 2'd0, 3'b010},  // R5 wrong locks player 2
    {1'b0, 3'b010, 1'b0, 1'b0, 2'd0, 3'b010},  // R4 locked press ignored
    {1'b0, 3'b111, 1'b0, 1'b0, 2'd1, 3'b010},  // R3 lowest eligible
    {1'b0, 3'b000, 1'b0, 1'b1, 2'd0, 3'b011},  // R5
    {1'b0, 3'b111, 1'b0, 1'b0, 2'd3, 3'b011},  // R3 only player 3 eligible
    {1'b0, 3'b000, 1'b0, 1'b1, 2'd0, 3'b111},  // R5 full lock
    {1'b0, 3'b111, 1'b0, 1'b0, 2'd0, 3'b111},  // R10 presses ignored
    {1'b0, 3'b000, 1'b1, 1'b0, 2'd0, 3'b111},  // R10 ruling ignored
    {1'b1, 3'b000, 1'b0, 1'b0, 2'd0, 3'b000},  // R1 clear
    {1'b0, 3'b110, 1'b0, 1'b0, 2'd2, 3'b000},  // R3 player 2 over 3
    {1'b0, 3'b000, 1'b1, 1'b1, 2'd0, 3'b000},  // R11 both rulings
    {1'b0, 3'b100, 1'b0, 1'b1, 2'd3, 3'b000},  // R9 bad ignored as idle, R2
    {1'b0, 3'b000, 1'b1, 1'b0, 2'd0, 3'b000},  // R7 correct
    {1'b1, 3'b001, 1'b0, 1'b0, 2'd0, 3'b000}   // R1 clear beats press
  };

  task automatic check_state(input string req, input logic [1:0] ec, input logic [2:0] el);
    logic [2:0] eg;
    eg = (ec == 2'd0) ? 3'b000 : 3'(1 << (ec - 2'd1));
    checks++;
    if (player_code_o !== ec || lock_o !== el || grant_o !== eg) begin
      fails++;
      $display("FAIL %s: code=%0d lock=%b grant=%b expected code=%0d lock=%b grant=%b",
               req, player_code_o, lock_o, grant_o, ec, el, eg);
    end
  endtask

  task automatic step(input logic c, input logic [2:0] b, input logic ok, input logic bad);
    clear_i = c; buzz_i = b; judge_ok_i = ok; judge_bad_i = bad;
    @(posedge clk);
    @(negedge clk);
    clear_i = 1'b0; buzz_i = '0; judge_ok_i = 1'b0; judge_bad_i = 1'b0;
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check_state("R1 reset", 2'd0, 3'b000);
    rst_n = 1'b1;
    @(negedge clk);
    check_state("R1 after release", 2'd0, 3'b000);

    for (int k = 0; k < NV; k++) begin
      step(VEC[k][10], VEC[k][9:7], VEC[k][6], VEC[k][5]);
      check_state($sformatf("vector %0d", k), VEC[k][4:3], VEC[k][2:0]);
    end

    // R2 player 1 alone, then async reset mid-answer (R1)
    step(1'b0, 3'b001, 1'b0, 1'b0);
    check_state("R2 player 1", 2'd1, 3'b000);
    step(1'b0, 3'b000, 1'b0, 1'b1);
    check_state("R5 player 1 locked", 2'd0, 3'b001);
    step(1'b0, 3'b011, 1'b0, 1'b0);
    check_state("R3 skip locked player 1", 2'd2, 3'b001);
    #3 rst_n = 1'b0;
    #2 check_state("R1 async reset", 2'd0, 3'b000);
    @(negedge clk);
    rst_n = 1'b1;
    // R7 correct after a wrong answer clears the earlier lock
    step(1'b0, 3'b100, 1'b0, 1'b0);
    step(1'b0, 3'b000, 1'b0, 1'b1);
    step(1'b0, 3'b001, 1'b0, 1'b0);
    check_state("R2 after lockout", 2'd1, 3'b100);
    step(1'b0, 3'b000, 1'b1, 1'b0);
    check_state("R7 clears locks", 2'd0, 3'b000);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule